// File: doc/BRIEF.md
# Three-Channel Match Timer

This peripheral holds a set of up-counters, three by default, that each run on a count clock with no fixed relation to the bus clock. Every counter feeds three comparators. When a running counter reaches a comparator's programmed value, a sticky status bit is raised in the bus domain. Status bits that software has enabled are merged into one registered interrupt line. Each counter is either free-running, wrapping at its full width, or periodic, returning to zero once it reaches the value in comparator 0. A period of N ticks is therefore programmed as N-1. Intervals shorter than 16 ticks are not supported, because each match event has to cross the clock boundary.

Software never reads the live count. A write to a timer's capture register sends a request toggle into the count domain. There, the count is latched and a done toggle comes back. The bus side then copies the frozen value into a snapshot that reads return. Until that copy takes place, a read returns the previous snapshot.

The bus port is a plain register port. A write completes in the cycle `wr_en` is high, and `rdata` follows `addr` combinationally. There is no stream data path and no back-pressure. Bus address 0x00 is the run register, with bit t for timer t. Timer t occupies the 32-byte window at (t+1)*0x20, with these offsets: 0x00 mode (bit 0: 1 = periodic), 0x04 interrupt enable, 0x08 status (write 1 to clear), 0x0C capture, and 0x10/0x14/0x18 for comparators 0/1/2. Match values and the mode bit must only be changed while their timer is stopped.

Top module: `mtm_top`

## Requirements
- R1: Bit t of the run register (address 0x00, read back as written) starts timer t. While that bit is 0, the count is held at zero, so a timer that is restarted counts again from zero.
- R2: In periodic mode (mode bit 0 = 1), a running counter that equals comparator 0 returns to zero on the next tick. Its count never exceeds that value, and comparator 0 matches once per period.
- R3: In free-running mode, the count goes up by one per count-clock tick and wraps modulo 2^CNT_W, where CNT_W is 32 by default.
- R4: Status bit k (bits 2:0 of the status register) is set when the running counter equals comparator k. Comparators that are never reached leave their bits clear.
- R5: A status bit stays set until a 1 is written to that bit position of the status register. Writing 0 to a bit leaves it unchanged. If a set and a clear reach a bit in the same cycle, the set wins.
- R6: `irq` is the OR, over all timers, of status AND interrupt enable, registered one bus cycle later. Status bits that are not enabled do not assert it.
- R7: A write to the capture register requests a snapshot. A read returns the captured count once the round trip through the two synchronizers has completed. A read before that point returns the previous snapshot, which stays unchanged until the next request.
- R8: After reset, every register reads zero and `irq` is low.
- R9: Timers are independent. A running timer never sets status bits in another timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| cnt_clk | input | 1 | Count clock, asynchronous to clk |
| cnt_rst_n | input | 1 | Count-domain asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench goes after the cases where a plausible design goes quietly wrong. A periodic timer must never show a count above its comparator-0 value, and its comparator 0 must fire again after status is cleared; a design that ignored the mode bit would wrap at full width and never fire again within the window. A capture read taken right after the request must still show the old snapshot, while later reads must hold steady; a design that forwarded the live count would show both failures. Restarting a stopped timer must yield a small count, which catches a design that only pauses. A partial write-1-clear must drop exactly the addressed bit, and masked status must keep `irq` low, so a design that clears whole registers or ignores the enables shows up.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = 5;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int DATA_W = 32;

  localparam logic [OFF_W-1:0] OFF_MODE = 5'h00;
  localparam logic [OFF_W-1:0] OFF_IE   = 5'h04;
  localparam logic [OFF_W-1:0] OFF_STAT = 5'h08;
  localparam logic [OFF_W-1:0] OFF_CAP  = 5'h0C;
  localparam int               OFF_M0   = 16;
  localparam int               OFF_STEP = 4;
endpackage

// File: rtl/mtm_sync.sv
module mtm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/mtm_counter.sv
// Count-domain half of one timer: counter, comparators, snapshot latch.
module mtm_counter #(
  parameter int CNT_W = 32,
  parameter int CMP_N = 3
) (
  input  logic                   cnt_clk,
  input  logic                   cnt_rst_n,
  input  logic                   en_req,
  input  logic                   periodic,
  input  logic [CMP_N*CNT_W-1:0] match_flat,
  input  logic                   cap_req_tgl,
  output logic                   run,
  output logic [CNT_W-1:0]       cnt,
  output logic [CMP_N-1:0]       hit_tgl,
  output logic [CNT_W-1:0]       snap,
  output logic                   cap_done_tgl
);
  logic             req_s, req_d;
  logic [CMP_N-1:0] hit;

  mtm_sync #(.W(1)) u_en_sync (
    .clk(cnt_clk), .rst_n(cnt_rst_n), .d(en_req), .q(run)
  );
  mtm_sync #(.W(1)) u_req_sync (
    .clk(cnt_clk), .rst_n(cnt_rst_n), .d(cap_req_tgl), .q(req_s)
  );

  for (genvar k = 0; k < CMP_N; k++) begin : g_cmp
    assign hit[k] = run && (cnt == match_flat[k*CNT_W +: CNT_W]);
  end

  always_ff @(posedge cnt_clk or negedge cnt_rst_n) begin
    if (!cnt_rst_n) begin
      cnt          <= '0;
      hit_tgl      <= '0;
      req_d        <= 1'b0;
      snap         <= '0;
      cap_done_tgl <= 1'b0;
    end else begin
      if (!run)                   cnt <= '0;
      else if (periodic && hit[0]) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
      hit_tgl <= hit_tgl ^ hit;
      req_d   <= req_s;
      if (req_s != req_d) begin
        snap         <= cnt;
        cap_done_tgl <= ~cap_done_tgl;
      end
    end
  end
endmodule

// File: rtl/mtm_top.sv
module mtm_top
  import mtm_pkg::*;
#(
  parameter int NT    = 3,
  parameter int CMP_N = 3,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_clk,
  input  logic              cnt_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [NT-1:0]       en_q;
  logic [OFF_W-1:0]    off;
  logic [DATA_W-1:0]   rd_t [NT];
  logic [NT*CMP_N-1:0] st_all, ie_all, set_all, clr_all;
  logic [NT-1:0]       run_all, per_all;
  logic [NT*CNT_W-1:0] cnt_all;

  assign off = addr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en && addr == '0) en_q <= wdata[NT-1:0];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic                   wsel, per_q, cap_q, done_s, done_d, done_c, run_c;
    logic [CMP_N-1:0]       ie_q, st_q, hit_t, hit_s, hit_d, set_p, clr_p;
    logic [CMP_N*CNT_W-1:0] m_q;
    logic [CNT_W-1:0]       snap_c, snap_q, cnt_c;
    logic [DATA_W-1:0]      rd_l;

    assign wsel  = wr_en && (addr[ADDR_W-1:OFF_W] == BLK_W'(t + 1));
    assign clr_p = (wsel && off == OFF_STAT) ? wdata[CMP_N-1:0] : '0;
    assign set_p = hit_s ^ hit_d;

    mtm_counter #(.CNT_W(CNT_W), .CMP_N(CMP_N)) u_cnt (
      .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n), .en_req(en_q[t]),
      .periodic(per_q), .match_flat(m_q), .cap_req_tgl(cap_q),
      .run(run_c), .cnt(cnt_c), .hit_tgl(hit_t), .snap(snap_c),
      .cap_done_tgl(done_c)
    );
    mtm_sync #(.W(CMP_N)) u_hit_sync (
      .clk(clk), .rst_n(rst_n), .d(hit_t), .q(hit_s)
    );
    mtm_sync #(.W(1)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done_c), .q(done_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q  <= 1'b0;
        ie_q   <= '0;
        st_q   <= '0;
        m_q    <= '0;
        cap_q  <= 1'b0;
        hit_d  <= '0;
        done_d <= 1'b0;
        snap_q <= '0;
      end else begin
        if (wsel && off == OFF_MODE) per_q <= wdata[0];
        if (wsel && off == OFF_IE)   ie_q  <= wdata[CMP_N-1:0];
        if (wsel && off == OFF_CAP)  cap_q <= ~cap_q;
        for (int k = 0; k < CMP_N; k++) begin
          if (wsel && off == OFF_W'(OFF_M0 + OFF_STEP*k))
            m_q[k*CNT_W +: CNT_W] <= wdata[CNT_W-1:0];
        end
        st_q   <= (st_q & ~clr_p) | set_p;
        hit_d  <= hit_s;
        done_d <= done_s;
        if (done_s != done_d) snap_q <= snap_c;
      end
    end

    always_comb begin
      rd_l = '0;
      case (off)
        OFF_MODE: rd_l[0]           = per_q;
        OFF_IE:   rd_l[CMP_N-1:0]   = ie_q;
        OFF_STAT: rd_l[CMP_N-1:0]   = st_q;
        OFF_CAP:  rd_l[CNT_W-1:0]   = snap_q;
        default: begin
          for (int k = 0; k < CMP_N; k++)
            if (off == OFF_W'(OFF_M0 + OFF_STEP*k))
              rd_l[CNT_W-1:0] = m_q[k*CNT_W +: CNT_W];
        end
      endcase
    end

    assign rd_t[t] = rd_l;
    assign st_all[t*CMP_N +: CMP_N]  = st_q;
    assign ie_all[t*CMP_N +: CMP_N]  = ie_q;
    assign set_all[t*CMP_N +: CMP_N] = set_p;
    assign clr_all[t*CMP_N +: CMP_N] = clr_p;
    assign run_all[t] = run_c;
    assign per_all[t] = per_q;
    assign cnt_all[t*CNT_W +: CNT_W] = cnt_c;
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata[NT-1:0] = en_q;
    for (int t = 0; t < NT; t++)
      if (addr[ADDR_W-1:OFF_W] == BLK_W'(t + 1)) rdata = rd_t[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(st_all & ie_all);
  end
endmodule

// File: rtl/mtm_top_chk.sv
module mtm_top_chk #(
  parameter int NT    = 3,
  parameter int CMP_N = 3,
  parameter int CNT_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cnt_clk,
  input logic                cnt_rst_n,
  input logic                irq,
  input logic [NT*CMP_N-1:0] st_all,
  input logic [NT*CMP_N-1:0] ie_all,
  input logic [NT*CMP_N-1:0] set_all,
  input logic [NT*CMP_N-1:0] clr_all,
  input logic [NT-1:0]       run_all,
  input logic [NT-1:0]       per_all,
  input logic [NT*CNT_W-1:0] cnt_all
);
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_all & ie_all)) |=> irq);
  p_irq_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st_all & ie_all)) |=> !irq);

  for (genvar i = 0; i < NT*CMP_N; i++) begin : g_bit
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_all[i] && !clr_all[i]) |=> st_all[i]);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_all[i] |=> st_all[i]);
  end

  for (genvar t = 0; t < NT; t++) begin : g_t
    p_stop_zero_r1: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      !run_all[t] |=> (cnt_all[t*CNT_W +: CNT_W] == '0));
    p_free_inc_r3: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      (run_all[t] && !per_all[t]) |=>
        (cnt_all[t*CNT_W +: CNT_W] == CNT_W'($past(cnt_all[t*CNT_W +: CNT_W]) + 1'b1)));
  end
endmodule

bind mtm_top mtm_top_chk #(.NT(NT), .CMP_N(CMP_N), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
  .irq(irq), .st_all(st_all), .ie_all(ie_all), .set_all(set_all),
  .clr_all(clr_all), .run_all(run_all), .per_all(per_all), .cnt_all(cnt_all)
);

// File: tb/mtm_top_tb.sv
module mtm_top_tb;
  localparam int CW = 10;

  logic        clk = 1'b0, cnt_clk = 1'b0;
  logic        rst_n = 1'b0, cnt_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #7 cnt_clk = ~cnt_clk;
  end

  mtm_top #(.NT(3), .CMP_N(3), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  tmr;
    logic        per;
    logic [9:0]  m0, m1, m2;
    logic [2:0]  ie;
    logic [15:0] wcyc;
    logic [2:0]  exp_st;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd0, 1'b0, 10'd20,  10'd40, 10'd900, 3'b001, 16'd200, 3'b011},
    '{2'd1, 1'b0, 10'd100, 10'd5,  10'd50,  3'b100, 16'd50,  3'b010},
    '{2'd2, 1'b1, 10'd30,  10'd40, 10'd10,  3'b110, 16'd300, 3'b101},
    '{2'd0, 1'b1, 10'd500, 10'd16, 10'd600, 3'b000, 16'd100, 3'b010}
  };

  function automatic logic [7:0] ra(input int t, input int off);
    return 8'((t + 1) * 32 + off);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input logic [31:0] act,
                         input logic [31:0] lo, input logic [31:0] hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic clear_all();
    wr(8'h00, 32'h0);
    idle(10);
    for (int t = 0; t < 3; t++) wr(ra(t, 8), 32'h7);
    idle(3);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v1, v2;
    idle(3);
    rst_n = 1'b1; cnt_rst_n = 1'b1;
    idle(2);

    // R8: reset state
    rd(8'h00, v);      chk("R8 run reg", v, 0);
    rd(ra(0, 8), v);   chk("R8 status", v, 0);
    rd(ra(2, 12), v);  chk("R8 capture", v, 0);
    rd(ra(1, 16), v);  chk("R8 match", v, 0);
    chk("R8 irq", {31'b0, irq}, 0);

    // R4 R6 R9 R2: vector table
    for (int i = 0; i < 4; i++) begin
      clear_all();
      wr(ra(VECS[i].tmr, 0),  {31'b0, VECS[i].per});
      wr(ra(VECS[i].tmr, 4),  {29'b0, VECS[i].ie});
      wr(ra(VECS[i].tmr, 16), {22'b0, VECS[i].m0});
      wr(ra(VECS[i].tmr, 20), {22'b0, VECS[i].m1});
      wr(ra(VECS[i].tmr, 24), {22'b0, VECS[i].m2});
      wr(8'h00, 32'(1) << VECS[i].tmr);
      idle(int'(VECS[i].wcyc));
      rd(ra(VECS[i].tmr, 8), v);
      chk("R4 status vector", v, {29'b0, VECS[i].exp_st});
      chk("R6 irq vector", {31'b0, irq}, {31'b0, |(VECS[i].exp_st & VECS[i].ie)});
      for (int t = 0; t < 3; t++)
        if (t != int'(VECS[i].tmr)) begin
          rd(ra(t, 8), v);
          chk("R9 other timer status", v, 0);
        end
    end

    // R7: capture handshake on free-running timer 0
    clear_all();
    wr(ra(0, 0), 32'h0);
    wr(ra(0, 16), 32'd1000); wr(ra(0, 20), 32'd1001); wr(ra(0, 24), 32'd1002);
    wr(8'h00, 32'h1);
    idle(99);
    wr(ra(0, 12), 32'h0);
    rd(ra(0, 12), v);    chk("R7 early read old snapshot", v, 0);
    idle(20);
    rd(ra(0, 12), v1);   chk_rng("R7 snapshot value", v1, 62, 80);
    idle(20);
    rd(ra(0, 12), v);    chk("R7 snapshot stable", v, v1);
    wr(ra(0, 12), 32'h0);
    idle(20);
    rd(ra(0, 12), v2);   chk_rng("R3 count advances", v2, v1 + 10, v1 + 40);

    // R1: restart counts from zero
    wr(8'h00, 32'h0);
    idle(10);
    wr(8'h00, 32'h1);
    rd(8'h00, v);        chk("R1 run readback", v, 1);
    idle(10);
    wr(ra(0, 12), 32'h0);
    idle(20);
    rd(ra(0, 12), v);    chk_rng("R1 restart from zero", v, 1, 12);

    // R2: periodic timer 2 stays within comparator 0 and re-fires
    clear_all();
    wr(ra(2, 0), 32'h1);
    wr(ra(2, 16), 32'd30); wr(ra(2, 20), 32'd40); wr(ra(2, 24), 32'd10);
    wr(8'h00, 32'h4);
    idle(50);
    for (int j = 0; j < 6; j++) begin
      wr(ra(2, 12), 32'h0);
      idle(17);
      rd(ra(2, 12), v);  chk_rng("R2 periodic bound", v, 0, 30);
    end
    wr(ra(2, 8), 32'h7);
    idle(60);
    rd(ra(2, 8), v);     chk("R2 reload re-fires", v & 32'h3, 32'h1);

    // R5: sticky status and partial clear on timer 1
    clear_all();
    wr(ra(1, 0), 32'h0);
    wr(ra(1, 4), 32'h0);
    wr(ra(1, 16), 32'd5); wr(ra(1, 20), 32'd8); wr(ra(1, 24), 32'd1000);
    wr(8'h00, 32'h2);
    idle(40);
    rd(ra(1, 8), v);     chk("R5 both set", v, 32'h3);
    wr(ra(1, 8), 32'h2);
    rd(ra(1, 8), v);     chk("R5 partial clear", v, 32'h1);
    idle(30);
    rd(ra(1, 8), v);     chk("R5 sticky", v, 32'h1);
    chk("R6 masked no irq", {31'b0, irq}, 0);

    // R3: wrap modulo 2^CW
    wr(ra(1, 8), 32'h7);
    idle(1500);
    rd(ra(1, 8), v);     chk("R3 wrap re-hits", v, 32'h7);

    clear_all();
    chk("R6 irq low after clear", {31'b0, irq}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule